// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in memory, with 4 KB pages. A client offers one logical address at a time. The walker first reads an entry from the top-level table, called the directory. That entry names the page that holds the second-level table. The walker then reads the leaf entry from that page and returns the frame number joined with the page offset. If either read finds an entry with its valid bit clear, the walk ends with a fault instead, and the fault names the level that failed.

The walker has a single memory read port and keeps one read in flight at a time. The directory's base address sits in a register that can be written while the walker is idle. The block does not cache translations, does not handle faults and does not allocate tables.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_rd_en`, `resp_valid`, `resp_fault` and `resp_fault_lvl` are all 0. The directory base register resets to the parameter `BASE_RST`, which is 0 by default.
- R2: The logical address splits into three fields. Bits 31:22 are the directory index, bits 21:12 are the leaf index and bits 11:0 are the offset. The first read of a walk is at `base + directory_index*4`.
- R3: A table entry is valid when bit 0 is 1. Its bits 31:12 hold a frame number. Bits 11:1 of an entry have no effect on the walk.
- R4: The second read is at `dir_frame*4096 + leaf_index*4`, where `dir_frame` is the frame number from the directory entry. This read is issued only after valid directory data has returned.
- R5: On a successful walk, `resp_valid` is high for exactly one cycle. In that cycle `resp_fault` is 0 and `resp_paddr` is `{leaf_frame, offset}`, where `leaf_frame` is the frame number from the leaf entry.
- R6: If the directory entry is invalid, the walk ends with `resp_fault`=1 and `resp_fault_lvl`=0. No second read is made, and `resp_paddr` is 0.
- R7: If the leaf entry is invalid, the walk ends with `resp_fault`=1, `resp_fault_lvl`=1 and `resp_paddr`=0.
- R8: `mem_rd_en` stays high, with `mem_rd_addr` held stable, until `mem_rd_valid` returns. The read may take any number of cycles.
- R9: `req_ready` is high only while the walker is idle. A request that arrives during a walk is not taken and does not change the result of that walk.
- R10: A write to the base register while the walker is idle takes effect from the next walk on. A base write during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New value for the directory base |
| req_valid | input | 1 | A translation request is offered |
| req_vaddr | input | 32 | Logical address to translate |
| req_ready | output | 1 | Walker is idle and takes the request |
| mem_rd_en | output | 1 | Read request to memory, held until the data returns |
| mem_rd_addr | output | 32 | Byte address of the table entry being read |
| mem_rd_valid | input | 1 | Read data is present this cycle |
| mem_rd_data | input | 32 | Table entry returned by memory |
| resp_valid | output | 1 | One-cycle pulse that carries the result of a walk |
| resp_paddr | output | 32 | Translated physical address, or 0 on a fault |
| resp_fault | output | 1 | The walk hit an invalid entry |
| resp_fault_lvl | output | 1 | Level of the invalid entry: 0 for directory, 1 for leaf |

## Verification
Addresses with both indices at zero, at one and at 1023 make sure the fields are cut at the right bit positions. Pointing both levels at different tables shows that the directory frame really selects the leaf page. Entries that are invalid at only one level show that a fault is reported at the correct level, and the count of reads issued shows that the walk stops early on a directory fault. A leaf entry with its low flag bits set tests R3. Read latencies of zero and several cycles test the hold behaviour. A base write and a competing request made during a walk show that R9 and R10 are kept apart.

// File: rtl/xlat_pkg.sv
// Shared definitions for the page table walker.
// Assumes each table entry is 4 bytes, so an index becomes a byte offset by a shift of 2.
package xlat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_LEAF,
        ST_OK,
        ST_FLT
    } walk_st_e;

    localparam int unsigned PTE_SHIFT = 2;
endpackage

// File: rtl/xlat_base_reg.sv
// Holds the directory base register.
// Assumes `idle` is high only while no walk is in progress. Writes made at other times are dropped.
module xlat_base_reg #(
    parameter int unsigned        ADDR_W  = 32,
    parameter logic [ADDR_W-1:0]  RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              idle,
    output logic [ADDR_W-1:0] base_q
);
    // Load a new base only while the walker is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= RST_VAL;
        end else if (wr_en && idle) begin
            base_q <= wr_data;
        end
    end
endmodule

// File: rtl/xlat_walk_ctl.sv
// Walk sequencer. It takes a request, waits for each table read to return,
// checks the valid bit and records the frame number or the level that faulted.
// Assumes memory answers each read exactly once, with mem_rd_valid.
module xlat_walk_ctl
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 12,
    localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               mem_rd_valid,
    input  logic [ADDR_W-1:0]  mem_rd_data,
    output walk_st_e           state_q,
    output logic [ADDR_W-1:0]  vaddr_q,
    output logic [FRAME_W-1:0] frame_q,
    output logic               flt_lvl_q
);
    logic entry_ok;
    logic unused_flags;

    assign entry_ok     = mem_rd_data[0];
    assign unused_flags = ^mem_rd_data[OFF_W-1:1];

    // Next state: one table read per level, then one cycle to report the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (req_valid) state_q <= ST_RD_DIR;
                ST_RD_DIR:  if (mem_rd_valid) state_q <= entry_ok ? ST_RD_LEAF : ST_FLT;
                ST_RD_LEAF: if (mem_rd_valid) state_q <= entry_ok ? ST_OK : ST_FLT;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the request address when the walker accepts a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            vaddr_q <= req_vaddr;
        end
    end

    // Frame latch. It holds the leaf-table frame after the directory read and the data frame after the leaf read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if ((state_q == ST_RD_DIR || state_q == ST_RD_LEAF) && mem_rd_valid) begin
            frame_q <= mem_rd_data[ADDR_W-1:OFF_W];
        end
    end

    // Record which level an invalid entry was found at.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_lvl_q <= 1'b0;
        end else if (mem_rd_valid && !entry_ok) begin
            if (state_q == ST_RD_DIR)       flt_lvl_q <= 1'b0;
            else if (state_q == ST_RD_LEAF) flt_lvl_q <= 1'b1;
        end
    end
endmodule

// File: rtl/xlat_addr_gen.sv
// Builds the entry address for each table read and the response fields, from the walk state.
// Purely combinational. Assumes the address is ADDR_W bits wide and splits as directory index, leaf index, then offset.
module xlat_addr_gen
    import xlat_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned IDX_W   = 10,
    localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
    input  walk_st_e           state_q,
    input  logic [ADDR_W-1:0]  base_q,
    input  logic [ADDR_W-1:0]  vaddr_q,
    input  logic [FRAME_W-1:0] frame_q,
    input  logic               flt_lvl_q,
    output logic               rd_en,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic               ready,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic               rsp_fault,
    output logic               rsp_lvl
);
    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  leaf_idx;
    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] leaf_addr;

    assign dir_idx   = vaddr_q[ADDR_W-1 -: IDX_W];
    assign leaf_idx  = vaddr_q[OFF_W +: IDX_W];
    assign dir_addr  = base_q + (ADDR_W'(dir_idx) << PTE_SHIFT);
    assign leaf_addr = {frame_q, {OFF_W{1'b0}}} | (ADDR_W'(leaf_idx) << PTE_SHIFT);

    // Choose the read address and the response fields for the current state.
    always_comb begin
        rd_en     = (state_q == ST_RD_DIR) || (state_q == ST_RD_LEAF);
        rd_addr   = (state_q == ST_RD_LEAF) ? leaf_addr : dir_addr;
        ready     = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_OK) || (state_q == ST_FLT);
        rsp_fault = (state_q == ST_FLT);
        rsp_lvl   = (state_q == ST_FLT) && flt_lvl_q;
        rsp_paddr = (state_q == ST_OK) ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/xlat_walker.sv
// Top level of the page table walker. It joins the base register, the walk sequencer and the address generator.
// Assumes ADDR_W = 2*IDX_W + OFF_W and one outstanding memory read at a time.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter int unsigned       OFF_W    = 12,
    parameter int unsigned       IDX_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic              resp_fault_lvl
);
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;

    walk_st_e           state_q;
    logic [ADDR_W-1:0]  base_q;
    logic [ADDR_W-1:0]  vaddr_q;
    logic [FRAME_W-1:0] frame_q;
    logic               flt_lvl_q;

    xlat_base_reg #(.ADDR_W(ADDR_W), .RST_VAL(BASE_RST)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr),
        .wr_data (base_wdata),
        .idle    (state_q == ST_IDLE),
        .base_q  (base_q)
    );

    xlat_walk_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .state_q      (state_q),
        .vaddr_q      (vaddr_q),
        .frame_q      (frame_q),
        .flt_lvl_q    (flt_lvl_q)
    );

    xlat_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_agen (
        .state_q   (state_q),
        .base_q    (base_q),
        .vaddr_q   (vaddr_q),
        .frame_q   (frame_q),
        .flt_lvl_q (flt_lvl_q),
        .rd_en     (mem_rd_en),
        .rd_addr   (mem_rd_addr),
        .ready     (req_ready),
        .rsp_valid (resp_valid),
        .rsp_paddr (resp_paddr),
        .rsp_fault (resp_fault),
        .rsp_lvl   (resp_fault_lvl)
    );
endmodule

// File: rtl/xlat_walker_chk.sv
// Protocol checker for xlat_walker. Looks only at the walker's ports and is attached by bind.
module xlat_walker_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic              resp_fault,
    input logic              resp_fault_lvl
);
    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_rd_en && !req_ready);                     // R2
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !mem_rd_valid |=> mem_rd_en && $stable(mem_rd_addr));      // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);                                             // R5
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> resp_paddr == '0);                          // R6
    AST_LVL_ONLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault_lvl |-> resp_fault && resp_valid);                            // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || resp_valid) |-> !req_ready);                               // R9
endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_rd_en      (mem_rd_en),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_valid   (mem_rd_valid),
    .resp_valid     (resp_valid),
    .resp_paddr     (resp_paddr),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl)
);

// File: tb/xlat_walker_test.sv
// Self-checking bench for xlat_walker. Memory is modelled as a sparse array that answers after a set latency.
module xlat_walker_test;
    typedef struct packed {
        logic [31:0] va;
        logic [31:0] pa;
        logic        flt;
        logic        lvl;
        int          lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_1ABC, 32'h1234_5ABC, 1'b0, 1'b0, 0},
        '{32'hFFFF_FFFF, 32'hABCD_EFFF, 1'b0, 1'b0, 2},
        '{32'h0000_0123, 32'h0000_0000, 1'b1, 1'b0, 1},
        '{32'h0040_2000, 32'h0000_0000, 1'b1, 1'b1, 0},
        '{32'hFFC0_0010, 32'h0000_1010, 1'b0, 1'b0, 3},
        '{32'hFFC0_1777, 32'h5555_5777, 1'b0, 1'b0, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_fault;
    logic        resp_fault_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int lat     = 0;
    int wait_c  = 0;
    int n_reads = 0;
    logic [31:0] addr_log [2];
    logic [31:0] pmem [int unsigned];

    logic [31:0] got_pa;
    logic        got_flt;
    logic        got_lvl;

    xlat_walker uut (.*);

    always #2 clk = ~clk;

    // Watchdog: an expired run counts as one failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Memory model: answers a held read after `lat` cycles, then drops valid for one cycle.
    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
            wait_c       <= 0;
        end else if (mem_rd_en) begin
            if (wait_c >= lat) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pmem.exists(mem_rd_addr) ? pmem[mem_rd_addr] : 32'h0;
                if (n_reads < 2) addr_log[n_reads] = mem_rd_addr;
                n_reads = n_reads + 1;
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one walk. If poke is set, a base write and a competing request are made during the walk.
    task automatic walk(input logic [31:0] va, input int l, input logic poke);
        lat     = l;
        n_reads = 0;
        addr_log[0] = '0;
        addr_log[1] = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            base_wr    = 1'b1;
            base_wdata = 32'h0070_0000;
            req_valid  = 1'b1;
            req_vaddr  = 32'h0000_0000;
            check(req_ready == 1'b0, "R9 ready low while busy", {31'b0, req_ready}, 32'h0);
            @(negedge clk);
            base_wr   = 1'b0;
            req_valid = 1'b0;
        end
        for (int i = 0; i < 200 && !resp_valid; i++) @(negedge clk);
        got_pa  = resp_paddr;
        got_flt = resp_fault;
        got_lvl = resp_fault_lvl;
        check(resp_valid == 1'b1, "R5 response seen", {31'b0, resp_valid}, 32'h1);
        @(negedge clk);
        check(resp_valid == 1'b0, "R5 response one cycle", {31'b0, resp_valid}, 32'h0);
    endtask

    initial begin
        // Table entries: bit 0 valid, bits 31:12 frame.
        pmem[32'h0010_0004] = 32'h0020_0001;
        pmem[32'h0010_0FFC] = 32'h0030_0001;
        pmem[32'h0020_0004] = 32'h1234_5001;
        pmem[32'h0030_0FFC] = 32'hABCD_E001;
        pmem[32'h0030_0000] = 32'h0000_1001;
        pmem[32'h0030_0004] = 32'h5555_5FFF;
        pmem[32'h0040_0004] = 32'h0030_0001;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
        check(mem_rd_en == 1'b0, "R1 no read in reset", {31'b0, mem_rd_en}, 32'h0);
        check(resp_valid == 1'b0, "R1 no response in reset", {31'b0, resp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_rd_en == 1'b0, "R1 idle after reset", {31'b0, req_ready}, 32'h1);

        // R1/R10: program the base while idle
        base_wr = 1'b1;
        base_wdata = 32'h0010_0000;
        @(negedge clk);
        base_wr = 1'b0;

        for (int v = 0; v < NV; v++) begin
            walk(VECS[v].va, VECS[v].lat, 1'b0);
            check(got_pa == VECS[v].pa, "R5 R3 paddr", got_pa, VECS[v].pa);
            check(got_flt == VECS[v].flt, "R6 R7 fault flag", {31'b0, got_flt}, {31'b0, VECS[v].flt});
            check(got_lvl == VECS[v].lvl, "R6 R7 fault level", {31'b0, got_lvl}, {31'b0, VECS[v].lvl});
            if (v == 0) begin
                check(addr_log[0] == 32'h0010_0004, "R2 directory address", addr_log[0], 32'h0010_0004);
                check(addr_log[1] == 32'h0020_0004, "R4 leaf address", addr_log[1], 32'h0020_0004);
            end
            if (v == 1) begin
                check(addr_log[0] == 32'h0010_0FFC, "R2 directory address max", addr_log[0], 32'h0010_0FFC);
                check(addr_log[1] == 32'h0030_0FFC, "R4 leaf address max", addr_log[1], 32'h0030_0FFC);
            end
            if (v == 2) check(n_reads == 1, "R6 no leaf read", n_reads, 1);
            if (v == 3) check(n_reads == 2, "R7 two reads", n_reads, 2);
            if (v == 4) check(n_reads == 2, "R8 reads with latency", n_reads, 2);
        end

        // R9 R10: base write and competing request during a walk are ignored
        walk(32'h0040_1ABC, 5, 1'b1);
        check(got_pa == 32'h1234_5ABC, "R9 walk result unchanged", got_pa, 32'h1234_5ABC);
        check(addr_log[0] == 32'h0010_0004, "R10 base kept during walk", addr_log[0], 32'h0010_0004);
        check(req_ready == 1'b1, "R9 ready after walk", {31'b0, req_ready}, 32'h1);
        walk(32'h0040_1ABC, 0, 1'b0);
        check(addr_log[0] == 32'h0010_0004, "R10 busy write dropped", addr_log[0], 32'h0010_0004);

        // R10: base write while idle takes effect on the next walk
        @(negedge clk);
        base_wr = 1'b1;
        base_wdata = 32'h0040_0000;
        @(negedge clk);
        base_wr = 1'b0;
        walk(32'h0040_1ABC, 1, 1'b0);
        check(addr_log[0] == 32'h0040_0004, "R10 new base used", addr_log[0], 32'h0040_0004);
        check(got_pa == 32'h5555_5ABC, "R10 R4 new table path", got_pa, 32'h5555_5ABC);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule